// File: doc/BRIEF.md
# Power-Down and Wake-Up Sequencer

This block controls how a small processor-based chip goes to sleep and comes back. Software writes a single request bit to enter power-down. The block then drops both the oscillator enable and the PLL enable and watches three wake inputs: a bus activity line, a primary wake pin and a secondary wake pin. Each wake input has its own enable bit and polarity bit. The secondary pin can also be handed over to general-purpose I/O, and in that mode it cannot wake the chip.

When a qualified wake input is seen, the block turns the oscillator and PLL back on and waits a fixed settle interval. Only after that interval does it raise a wake interrupt. The interrupt stays pending until software clears it, and a cause field records which inputs were active at the moment of wake.

The same block also lengthens the external reset. The reset output stays asserted for a minimum number of cycles after the reset pin is released. That minimum is long on a cold start in crystal mode and short in external-clock mode or for any later reset. All timing is counted on one always-on low-speed reference clock. The reset pin is assumed to be synchronous to that clock.

Top module: `pdn_wake_ctrl`

## Requirements
- R1: A write to address 0 with data bit 0 set drives `osc_en` and `pll_en` low one cycle later. A write to address 0 with bit 0 clear, or a write to the unused address 3, leaves both enables high.
- R2: Once powered down, `osc_en` and `pll_en` stay low until a qualified wake input arrives.
- R3: When a qualified wake input changes at the ports, `osc_en` and `pll_en` rise 3 cycles later: two synchronizer flops plus the state register. `wake_irq` rises exactly `PLL_SETTLE_CYC` cycles after that.
- R4: The wake-configuration register is at address 1. Bits [2:0] are the enables, bits [5:3] are the polarities (1 means active high), and bit 6 puts the secondary pin into GPIO mode. Within each 3-bit field, bit 0 is bus activity, bit 1 is the primary pin and bit 2 is the secondary pin. After reset the register holds 0x0F: all sources enabled, bus activity active high, both pins active low. Each source can wake the block, and the cause field reports it in the same bit order.
- R5: Setting a pin's polarity bit makes a high level, rather than a low level, wake the block. With that bit set, a low level does not wake it.
- R6: In GPIO mode the secondary pin never wakes the block and is never recorded in the cause.
- R7: A disabled source has no effect. With bus activity disabled, the primary pin wakes the block whatever level the bus activity line holds.
- R8: A wake input seen during the settle interval is absorbed. It does not restart the interval, it does not add to the cause, and it does not produce a second interrupt.
- R9: `wake_irq` stays high until a write to address 2 with bit 0 set. That write clears `wake_irq` and `wake_cause` one cycle later. `wake_cause` holds the sources that were asserted when the wake was taken.
- R10: A clear write that reaches the block during the settle interval, including the cycle in which the interrupt is raised, is ignored. The interrupt stays pending.
- R11: `sys_rst_n` goes low one cycle after `rst_pin_n` is sampled low. After `rst_pin_n` is released, `sys_rst_n` stays low for `XTAL_RST_CYC` more cycles on a cold start with `xtal_mode` high. It stays low for `EXT_RST_CYC` more cycles in external-clock mode or after any earlier completed reset.
- R12: While reset is held, and right after it, `osc_en` and `pll_en` are high and `wake_irq` and `wake_cause` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on low-speed reference clock |
| por_n | input | 1 | Cold power-on indication, active low |
| rst_pin_n | input | 1 | Reset pin, active low |
| xtal_mode | input | 1 | Clock source strap: 1 = crystal, 0 = external clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 7 | Register write data |
| bus_activity | input | 1 | Bus activity wake input |
| wake_pin | input | 1 | Primary wake pin |
| wake_pin2 | input | 1 | Secondary wake pin, shareable with GPIO |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| wake_irq | output | 1 | Pending wake interrupt |
| wake_cause | output | 3 | Sources active when the wake was taken |
| sys_rst_n | output | 1 | Stretched reset, active low |

## Verification
Two events can land on the same clock edge: the end of the settle interval raises the interrupt, and a software clear write tries to drop it. The bench provokes this by timing a clear write so that it is sampled on exactly the edge where the interrupt is set. It then confirms that `wake_irq` is still high and the cause unchanged two cycles later. A second overlap is tested the same way: a fresh wake pulse on another enabled source during the settle wait. That case is judged by the interrupt rising on the original cycle, the cause excluding the late source, and no further interrupt after the clear.

// File: rtl/pwrwake_pkg.sv
// Shared definitions for the power-down and wake-up sequencer.
// Assumes all users run on the single always-on reference clock.
package pwrwake_pkg;

    typedef enum logic [1:0] {
        PS_RUN    = 2'd0,
        PS_DOWN   = 2'd1,
        PS_SETTLE = 2'd2
    } pstate_t;

    localparam int unsigned NSRC     = 3;
    localparam int unsigned SRC_BUS  = 0;
    localparam int unsigned SRC_PIN  = 1;
    localparam int unsigned SRC_PIN2 = 2;

    localparam logic [1:0] ADDR_PCTL = 2'd0;
    localparam logic [1:0] ADDR_WCFG = 2'd1;
    localparam logic [1:0] ADDR_ICLR = 2'd2;

endpackage

// File: rtl/wake_input_qual.sv
// Synchronizes one wake input and qualifies it with enable, polarity and,
// for a shareable pin, the GPIO-mode override.
// Assumes raw is asynchronous to clk; hit is valid two edges after a change.
module wake_input_qual #(
    parameter bit MUXABLE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic en,
    input  logic pol,
    input  logic gpio_mode,
    output logic hit
);
    logic s1_q, s2_q;

    // Two-flop synchronizer for the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= raw;
            s2_q <= s1_q;
        end
    end

    // Asserted when the synchronized level matches the active polarity.
    always_comb begin
        hit = en && (s2_q == pol) && !(MUXABLE && gpio_mode);
    end

endmodule

// File: rtl/rst_stretch.sv
// Lengthens the external reset: the output stays asserted while the pin
// is low and for a minimum count after release. The count is long only on
// a cold start in crystal mode.
// Assumes rst_pin_n is synchronous to clk; por_n marks a cold start.
module rst_stretch #(
    parameter int unsigned XTAL_CYC = 160,
    parameter int unsigned EXT_CYC  = 7
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_pin_n,
    input  logic xtal_mode,
    output logic rst_out_n
);
    localparam int unsigned MAXC = (XTAL_CYC > EXT_CYC) ? XTAL_CYC : EXT_CYC;
    localparam int unsigned CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;
    logic          warm_q;
    logic          out_q;

    // Chooses the hold length from clock mode and warm-start state.
    always_comb begin
        lim = (xtal_mode && !warm_q) ? CW'(XTAL_CYC) : CW'(EXT_CYC);
    end

    // Counts cycles after pin release and releases the output at the limit.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            cnt_q  <= '0;
            out_q  <= 1'b0;
            warm_q <= 1'b0;
        end else if (!rst_pin_n) begin
            cnt_q <= '0;
            out_q <= 1'b0;
        end else if (!out_q) begin
            if (cnt_q == lim) begin
                out_q  <= 1'b1;
                warm_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign rst_out_n = out_q;

    a_r11_pin_holds_reset: assert property (@(posedge clk) disable iff (!por_n)
        !rst_pin_n |=> !rst_out_n);

    a_r11_release_needs_pin: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_out_n) |-> $past(rst_pin_n));

endmodule

// File: rtl/pdn_fsm.sv
// Power state machine: run, powered down, PLL settle. Clocks are gated
// only in the down state; the settle wait is a fixed count.
// Assumes wake_any is already synchronized and qualified.
module pdn_fsm
    import pwrwake_pkg::*;
#(
    parameter int unsigned SETTLE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_req,
    input  logic wake_any,
    output logic osc_en,
    output logic pll_en,
    output logic wake_take,
    output logic wake_done,
    output logic settling
);
    localparam int unsigned SW = $clog2(SETTLE_CYC + 1);
    localparam logic [SW-1:0] LAST = SW'(SETTLE_CYC - 1);

    pstate_t       state_q;
    logic [SW-1:0] cnt_q;

    // State register and settle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_RUN;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                PS_RUN: begin
                    if (pd_req) state_q <= PS_DOWN;
                end
                PS_DOWN: begin
                    if (wake_any) begin
                        state_q <= PS_SETTLE;
                        cnt_q   <= '0;
                    end
                end
                PS_SETTLE: begin
                    if (cnt_q == LAST) state_q <= PS_RUN;
                    else               cnt_q   <= cnt_q + 1'b1;
                end
                default: state_q <= PS_RUN;
            endcase
        end
    end

    // Decodes clock enables and event strobes from the state.
    always_comb begin
        osc_en    = (state_q != PS_DOWN);
        pll_en    = (state_q != PS_DOWN);
        wake_take = (state_q == PS_DOWN) && wake_any;
        settling  = (state_q == PS_SETTLE);
        wake_done = (state_q == PS_SETTLE) && (cnt_q == LAST);
    end

    a_r1_gate_only_on_request: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_en) |-> $past(pd_req));

    a_r8_settle_not_restarted: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_SETTLE && cnt_q != LAST) |=>
            (state_q == PS_SETTLE && cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/pdn_wake_ctrl.sv
// Top of the power-down and wake-up sequencer: register write decode, wake
// configuration, per-source qualifiers, state machine, interrupt and cause
// capture, and reset stretching.
// Assumes one always-on reference clock; the processor writes registers.
module pdn_wake_ctrl
    import pwrwake_pkg::*;
#(
    parameter int unsigned XTAL_RST_CYC   = 160,
    parameter int unsigned EXT_RST_CYC    = 7,
    parameter int unsigned PLL_SETTLE_CYC = 16,
    parameter int unsigned WDATA_W        = 7
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               rst_pin_n,
    input  logic               xtal_mode,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [WDATA_W-1:0] wr_data,
    input  logic               bus_activity,
    input  logic               wake_pin,
    input  logic               wake_pin2,
    output logic               osc_en,
    output logic               pll_en,
    output logic               wake_irq,
    output logic [NSRC-1:0]    wake_cause,
    output logic               sys_rst_n
);
    localparam logic [NSRC-1:0] EN_RST  = '1;
    localparam logic [NSRC-1:0] POL_RST = NSRC'(1 << SRC_BUS);

    logic            stretched_n;
    logic            core_rst_n;
    logic            pd_req, iclr, cfg_wr;
    logic [NSRC-1:0] cfg_en_q, cfg_pol_q;
    logic            cfg_gpio_q;
    logic [NSRC-1:0] raw_vec, hits;
    logic            wake_take, wake_done, fsm_settling;
    logic            irq_q;
    logic [NSRC-1:0] cause_q;

    rst_stretch #(
        .XTAL_CYC (XTAL_RST_CYC),
        .EXT_CYC  (EXT_RST_CYC)
    ) u_stretch (
        .clk       (clk),
        .por_n     (por_n),
        .rst_pin_n (rst_pin_n),
        .xtal_mode (xtal_mode),
        .rst_out_n (stretched_n)
    );

    assign core_rst_n = por_n & stretched_n;
    assign sys_rst_n  = stretched_n;

    // Decodes the register write port into strobes.
    always_comb begin
        pd_req = wr_en && (wr_addr == ADDR_PCTL) && wr_data[0];
        iclr   = wr_en && (wr_addr == ADDR_ICLR) && wr_data[0];
        cfg_wr = wr_en && (wr_addr == ADDR_WCFG);
    end

    // Wake configuration register: enables, polarities, GPIO mode.
    always_ff @(posedge clk) begin
        if (!core_rst_n) begin
            cfg_en_q   <= EN_RST;
            cfg_pol_q  <= POL_RST;
            cfg_gpio_q <= 1'b0;
        end else if (cfg_wr) begin
            cfg_en_q   <= wr_data[NSRC-1:0];
            cfg_pol_q  <= wr_data[2*NSRC-1:NSRC];
            cfg_gpio_q <= wr_data[2*NSRC];
        end
    end

    assign raw_vec[SRC_BUS]  = bus_activity;
    assign raw_vec[SRC_PIN]  = wake_pin;
    assign raw_vec[SRC_PIN2] = wake_pin2;

    for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
        wake_input_qual #(
            .MUXABLE (gi == SRC_PIN2)
        ) u_qual (
            .clk       (clk),
            .rst_n     (core_rst_n),
            .raw       (raw_vec[gi]),
            .en        (cfg_en_q[gi]),
            .pol       (cfg_pol_q[gi]),
            .gpio_mode (cfg_gpio_q),
            .hit       (hits[gi])
        );
    end

    pdn_fsm #(
        .SETTLE_CYC (PLL_SETTLE_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (core_rst_n),
        .pd_req    (pd_req),
        .wake_any  (|hits),
        .osc_en    (osc_en),
        .pll_en    (pll_en),
        .wake_take (wake_take),
        .wake_done (wake_done),
        .settling  (fsm_settling)
    );

    // Interrupt pending flag and cause; set wins and clears wait out the settle.
    always_ff @(posedge clk) begin
        if (!core_rst_n) begin
            irq_q   <= 1'b0;
            cause_q <= '0;
        end else begin
            if (wake_take) cause_q <= hits;
            else if (iclr && !fsm_settling) cause_q <= '0;
            if (wake_done) irq_q <= 1'b1;
            else if (iclr && !fsm_settling) irq_q <= 1'b0;
        end
    end

    assign wake_irq   = irq_q;
    assign wake_cause = cause_q;

    a_r9_irq_has_cause: assert property (@(posedge clk) disable iff (!core_rst_n)
        irq_q |-> (cause_q != '0));

    a_r3_irq_after_settle: assert property (@(posedge clk) disable iff (!core_rst_n)
        $rose(irq_q) |-> $past(fsm_settling));

    a_r6_gpio_never_cause: assert property (@(posedge clk) disable iff (!core_rst_n)
        $rose(cause_q[SRC_PIN2]) |-> !$past(cfg_gpio_q));

endmodule

// File: tb/pdn_wake_ctrl_test.sv
`timescale 1ns/1ps
module pdn_wake_ctrl_test;
    localparam int XT = 40;
    localparam int EX = 12;
    localparam int S  = 6;
    localparam int F_OSC = 0, F_PLL = 1, F_IRQ = 2, F_CAUSE = 3, F_RST = 4;

    typedef struct {
        int    due;
        int    fld;
        int    exp;
        string req;
    } item_t;

    logic       clk = 1'b0;
    logic       por_n = 1'b0, rst_pin_n = 1'b0, xtal_mode = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [6:0] wr_data = 7'd0;
    logic       bus_activity = 1'b0, wake_pin = 1'b1, wake_pin2 = 1'b1;
    logic       osc_en, pll_en, wake_irq, sys_rst_n;
    logic [2:0] wake_cause;

    item_t sbq[$];
    int    cyc = 0, nchk = 0, nerr = 0;
    bit    done = 1'b0;

    pdn_wake_ctrl #(
        .XTAL_RST_CYC (XT), .EXT_RST_CYC (EX), .PLL_SETTLE_CYC (S), .WDATA_W (7)
    ) uut (
        .clk (clk), .por_n (por_n), .rst_pin_n (rst_pin_n), .xtal_mode (xtal_mode),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .bus_activity (bus_activity), .wake_pin (wake_pin), .wake_pin2 (wake_pin2),
        .osc_en (osc_en), .pll_en (pll_en), .wake_irq (wake_irq),
        .wake_cause (wake_cause), .sys_rst_n (sys_rst_n)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int observe(int f);
        case (f)
            F_OSC:   return int'(osc_en);
            F_PLL:   return int'(pll_en);
            F_IRQ:   return int'(wake_irq);
            F_CAUSE: return int'(wake_cause);
            default: return int'(sys_rst_n);
        endcase
    endfunction

    // Monitor: pops due items and compares them with the ports.
    always @(negedge clk) begin
        for (int i = sbq.size() - 1; i >= 0; i--) begin
            if (sbq[i].due == cyc) begin
                nchk++;
                if (observe(sbq[i].fld) !== sbq[i].exp) begin
                    nerr++;
                    $display("FAIL %s field=%0d actual=%0h expected=%0h",
                             sbq[i].req, sbq[i].fld, observe(sbq[i].fld), sbq[i].exp);
                end
                sbq.delete(i);
            end
        end
    end

    task automatic expect_at(int dly, int fld, int val, string req);
        item_t it;
        it.due = cyc + dly; it.fld = fld; it.exp = val; it.req = req;
        sbq.push_back(it);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [6:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic enter_pd();
        expect_at(1, F_OSC, 0, "R1");
        expect_at(1, F_PLL, 0, "R1");
        wr(2'd0, 7'h01);
        step(3);
    endtask

    task automatic expect_wake(int cause, string req);
        expect_at(2, F_OSC, 0, "R3");
        expect_at(3, F_OSC, 1, req);
        expect_at(3, F_PLL, 1, "R3");
        expect_at(2 + S, F_IRQ, 0, "R3");
        expect_at(3 + S, F_IRQ, 1, req);
        expect_at(3 + S, F_CAUSE, cause, req);
    endtask

    task automatic clear_irq();
        expect_at(1, F_IRQ, 0, "R9");
        expect_at(1, F_CAUSE, 0, "R9");
        wr(2'd2, 7'h01);
        step(2);
    endtask

    initial begin
        step(3);
        // R12: state while reset is held
        expect_at(1, F_RST, 0, "R11");
        expect_at(1, F_OSC, 1, "R12");
        expect_at(1, F_IRQ, 0, "R12");
        expect_at(1, F_CAUSE, 0, "R12");
        step(1);
        // R11: cold start in crystal mode
        expect_at(XT, F_RST, 0, "R11");
        expect_at(XT + 1, F_RST, 1, "R11");
        por_n = 1'b1; rst_pin_n = 1'b1;
        step(XT + 3);

        // R1: writes without the request bit leave clocks running
        expect_at(1, F_OSC, 1, "R1");
        wr(2'd0, 7'h00);
        expect_at(1, F_PLL, 1, "R1");
        wr(2'd3, 7'h01);
        step(2);

        // R2, R3, R4: primary pin wake with default (active-low) polarity
        enter_pd();
        expect_at(1, F_OSC, 0, "R2");
        step(3);
        expect_wake(3'b010, "R4");
        wake_pin = 1'b0; step(2); wake_pin = 1'b1;
        step(S + 6);
        expect_at(1, F_IRQ, 1, "R9");
        step(2);
        clear_irq();

        // R8: second events during settle are absorbed
        enter_pd();
        expect_wake(3'b010, "R8");
        expect_at(10 + S, F_IRQ, 1, "R8");
        wake_pin = 1'b0; step(2); wake_pin = 1'b1; step(1);
        bus_activity = 1'b1; wake_pin = 1'b0; step(3);
        bus_activity = 1'b0; wake_pin = 1'b1;
        step(S + 6);
        expect_at(1, F_IRQ, 0, "R8");
        expect_at(12, F_IRQ, 0, "R8");
        wr(2'd2, 7'h01);
        step(14);

        // R10: clear write on the same edge the interrupt is raised
        enter_pd();
        expect_wake(3'b010, "R10");
        expect_at(5 + S, F_IRQ, 1, "R10");
        expect_at(5 + S, F_CAUSE, 3'b010, "R10");
        wake_pin = 1'b0; step(2); wake_pin = 1'b1;
        step(S);
        wr(2'd2, 7'h01);
        step(4);
        clear_irq();

        // R5: primary pin made active high (cfg 0x1F)
        wr(2'd1, 7'h1F);
        wake_pin = 1'b0;
        step(4);
        enter_pd();
        expect_at(3, F_OSC, 0, "R5");
        step(4);
        expect_wake(3'b010, "R5");
        wake_pin = 1'b1;
        step(S + 5);
        clear_irq();
        wr(2'd1, 7'h0F);
        step(3);

        // R6: secondary pin in GPIO mode cannot wake; bus activity then wakes
        wr(2'd1, 7'h4F);
        step(2);
        enter_pd();
        wake_pin2 = 1'b0;
        expect_at(8, F_OSC, 0, "R6");
        step(9);
        expect_wake(3'b001, "R6");
        bus_activity = 1'b1;
        step(S + 5);
        bus_activity = 1'b0; wake_pin2 = 1'b1;
        clear_irq();
        wr(2'd1, 7'h0F);
        step(3);

        // R7: bus source disabled and held high; primary pin still wakes
        wr(2'd1, 7'h0E);
        bus_activity = 1'b1;
        step(3);
        enter_pd();
        expect_at(6, F_OSC, 0, "R7");
        step(7);
        expect_wake(3'b010, "R7");
        wake_pin = 1'b0; step(2); wake_pin = 1'b1;
        step(S + 4);
        bus_activity = 1'b0;
        clear_irq();
        wr(2'd1, 7'h0F);
        step(3);

        // R4: secondary pin wakes with default configuration
        enter_pd();
        expect_wake(3'b100, "R4");
        wake_pin2 = 1'b0; step(2); wake_pin2 = 1'b1;
        step(S + 4);

        // R11, R12: reset while powered uses the short hold even in crystal mode
        expect_at(1, F_RST, 0, "R11");
        rst_pin_n = 1'b0;
        step(3);
        expect_at(EX, F_RST, 0, "R11");
        expect_at(EX + 1, F_RST, 1, "R11");
        expect_at(EX + 1, F_IRQ, 0, "R12");
        expect_at(EX + 1, F_CAUSE, 0, "R12");
        expect_at(EX + 1, F_OSC, 1, "R12");
        rst_pin_n = 1'b1;
        step(EX + 3);

        // R11: cold start in external-clock mode
        xtal_mode = 1'b0; por_n = 1'b0; rst_pin_n = 1'b0;
        step(3);
        expect_at(EX, F_RST, 0, "R11");
        expect_at(EX + 1, F_RST, 1, "R11");
        por_n = 1'b1; rst_pin_n = 1'b1;
        step(EX + 3);

        step(2);
        if (sbq.size() != 0) begin
            nerr += sbq.size();
            nchk += sbq.size();
            $display("FAIL R3 unchecked items actual=%0d expected=0", sbq.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL R2 watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule